// File: doc/BRIEF.md
# Memory Region Attribute Decoder

This block maps a 32-bit physical address to an 8-bit region property byte and to a set of decoded attribute flags. The mapping comes from a single 64-bit configuration word. The word holds two boundaries at 4 KB page granularity: a top-of-system-memory page and a boot ROM base page. It also holds three property bytes, one for each of the zones these boundaries form.

Pages below the top of system memory belong to the system zone. Pages from the top up to, but not including, the ROM base belong to the device zone. Pages at or above the ROM base belong to the ROM zone. Inside the system zone, the fixed legacy window 000A0000h to 000FFFFFh overrides the system property with a property byte supplied on an input port. The address-to-property path is purely combinational. The configuration word sits behind a simple write-enable and read-data port, and a write changes the decode from the next cycle.

Top module: `mem_region_decode`

## Requirements
- R1: The configuration word is laid out as ROM property [63:56], ROM base page [55:36], device property [35:28], system top page [27:8] and system property [7:0]. The reserved bits 63:62, 35:34 and 7:6 always read back as zero.
- R2: A synchronous active-high reset loads the word 01FFFFF0_10000001h, so every zone decodes as cache-disabled (property 01h).
- R3: When `cfg_we` is high at a rising clock edge, `cfg_wdata` (with its reserved bits cleared) appears on `cfg_rdata` and drives the decode from the following cycle. Without a write, the word holds its value.
- R4: If address bits 31:12 are greater than or equal to the ROM base page, the output is the ROM property and `zone_out` is 2. This holds even when the system top page lies above the ROM base.
- R5: If address bits 31:12 are at or above the system top page and below the ROM base page, the output is the device property and `zone_out` is 1.
- R6: If address bits 31:12 are below both the system top page and the ROM base page, and the address lies outside the legacy window, the output is the system property and `zone_out` is 0.
- R7: If an address in 000A0000h..000FFFFFh would decode to the system zone, the output is `legacy_prop` and `zone_out` is 3. The window has no effect in any other zone.
- R8: The flags follow the selected byte: bit 0 cache-disable, bit 1 write-allocate, bit 2 write-protect, bit 3 write-through, bit 4 write-combine, bit 5 write-serialize.
- R9: Bits 7:6 of `prop_out` are always zero, whatever the reserved bits of `legacy_prop` or `cfg_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Current configuration word |
| phys_addr | input | 32 | Physical address to classify |
| legacy_prop | input | 8 | Property byte for the legacy window |
| prop_out | output | 8 | Selected property byte |
| zone_out | output | 2 | Zone code: 0 system, 1 device, 2 ROM, 3 legacy |
| attr_cd | output | 1 | Cache disable |
| attr_wa | output | 1 | Write allocate |
| attr_wp | output | 1 | Write protect |
| attr_wt | output | 1 | Write through |
| attr_wc | output | 1 | Write combine |
| attr_ws | output | 1 | Write serialize |

## Verification
The configuration word is the only internal state. A wrong stored value shows on `cfg_rdata` one cycle after the write that caused it. For every address it also shows as a wrong `prop_out` and `zone_out` in the same cycle. The comparisons that matter most are the page-boundary ones: one page below and at each boundary, both ends of the legacy window, and a word whose system top lies above its ROM base. An off-by-one or a swapped comparison changes the zone only at those addresses.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int CFG_W   = 64;
  localparam int ADDR_W  = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W  = ADDR_W - PAGE_LSB;
  localparam int PROP_W  = 8;
  localparam int ATTR_W  = 6;

  // field positions (low bit of each)
  localparam int SYSP_LO = 0;
  localparam int TOP_LO  = SYSP_LO + PROP_W;
  localparam int DEVP_LO = TOP_LO + PAGE_W;
  localparam int BASE_LO = DEVP_LO + PROP_W;
  localparam int ROMP_LO = BASE_LO + PAGE_W;

  localparam logic [PROP_W-1:0] PROP_KEEP = {{(PROP_W-ATTR_W){1'b0}}, {ATTR_W{1'b1}}};
  localparam logic [CFG_W-1:0] CFG_KEEP = {PROP_KEEP, {PAGE_W{1'b1}}, PROP_KEEP,
                                           {PAGE_W{1'b1}}, PROP_KEEP};

  typedef enum logic [1:0] {
    ZN_SYS = 2'd0,
    ZN_DEV = 2'd1,
    ZN_ROM = 2'd2,
    ZN_LEG = 2'd3
  } zone_e;

  typedef struct packed {
    logic [PROP_W-1:0] rom_prop;
    logic [PAGE_W-1:0] rom_page;
    logic [PROP_W-1:0] dev_prop;
    logic [PAGE_W-1:0] top_page;
    logic [PROP_W-1:0] sys_prop;
  } cfg_t;
endpackage

// File: rtl/mrd_cfg_reg.sv
module mrd_cfg_reg
  import mrd_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_WORD = 64'h01FF_FFF0_1000_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= RESET_WORD & CFG_KEEP;
    end else if (we) begin
      word_q <= wdata & CFG_KEEP;
    end
  end

  assign cfg = cfg_t'(word_q);
endmodule

// File: rtl/mrd_zone_sel.sv
module mrd_zone_sel
  import mrd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h000F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] rom_page,
  input  logic [PAGE_W-1:0] top_page,
  output zone_e             zone
);
  logic [PAGE_W-1:0] page;
  logic at_rom, at_dev, in_win;

  assign page   = addr[ADDR_W-1:PAGE_LSB];
  assign at_rom = (page >= rom_page);
  assign at_dev = (page >= top_page);
  assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);

  always_comb begin
    if (at_rom)      zone = ZN_ROM;
    else if (at_dev) zone = ZN_DEV;
    else if (in_win) zone = ZN_LEG;
    else             zone = ZN_SYS;
  end
endmodule

// File: rtl/mrd_prop_out.sv
module mrd_prop_out
  import mrd_pkg::*;
(
  input  zone_e             zone,
  input  logic [PROP_W-1:0] sys_prop,
  input  logic [PROP_W-1:0] dev_prop,
  input  logic [PROP_W-1:0] rom_prop,
  input  logic [PROP_W-1:0] leg_prop,
  output logic [PROP_W-1:0] prop,
  output logic [ATTR_W-1:0] attr
);
  logic [PROP_W-1:0] pick;

  always_comb begin
    unique case (zone)
      ZN_SYS:  pick = sys_prop;
      ZN_DEV:  pick = dev_prop;
      ZN_ROM:  pick = rom_prop;
      default: pick = leg_prop;
    endcase
  end

  assign prop = pick & PROP_KEEP;

  for (genvar i = 0; i < ATTR_W; i++) begin : g_attr
    assign attr[i] = prop[i];
  end
endmodule

// File: rtl/mem_region_decode.sv
module mem_region_decode
  import mrd_pkg::*;
#(
  parameter logic [63:0] RESET_WORD = 64'h01FF_FFF0_1000_0001,
  parameter logic [31:0] WIN_LO     = 32'h000A_0000,
  parameter logic [31:0] WIN_HI     = 32'h000F_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  input  logic [31:0] phys_addr,
  input  logic [7:0]  legacy_prop,
  output logic [7:0]  prop_out,
  output logic [1:0]  zone_out,
  output logic        attr_cd,
  output logic        attr_wa,
  output logic        attr_wp,
  output logic        attr_wt,
  output logic        attr_wc,
  output logic        attr_ws
);
  cfg_t              cfg;
  zone_e             zone;
  logic [ATTR_W-1:0] attr;

  mrd_cfg_reg #(.RESET_WORD(RESET_WORD)) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(cfg_wdata),
    .cfg  (cfg)
  );

  mrd_zone_sel #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_zone (
    .addr    (phys_addr),
    .rom_page(cfg.rom_page),
    .top_page(cfg.top_page),
    .zone    (zone)
  );

  mrd_prop_out u_prop (
    .zone    (zone),
    .sys_prop(cfg.sys_prop),
    .dev_prop(cfg.dev_prop),
    .rom_prop(cfg.rom_prop),
    .leg_prop(legacy_prop),
    .prop    (prop_out),
    .attr    (attr)
  );

  assign cfg_rdata = cfg;
  assign zone_out  = zone;
  assign attr_cd   = attr[0];
  assign attr_wa   = attr[1];
  assign attr_wp   = attr[2];
  assign attr_wt   = attr[3];
  assign attr_wc   = attr[4];
  assign attr_ws   = attr[5];
endmodule

// File: rtl/mrd_chk.sv
module mrd_chk #(
  parameter logic [63:0] RESET_WORD = 64'h01FF_FFF0_1000_0001,
  parameter logic [31:0] WIN_LO     = 32'h000A_0000,
  parameter logic [31:0] WIN_HI     = 32'h000F_FFFF
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [63:0] cfg_wdata,
  input logic [63:0] cfg_rdata,
  input logic [31:0] phys_addr,
  input logic [7:0]  prop_out,
  input logic [1:0]  zone_out,
  input logic        attr_cd,
  input logic        attr_wa,
  input logic        attr_wp,
  input logic        attr_wt,
  input logic        attr_wc,
  input logic        attr_ws
);
  localparam logic [63:0] KEEP = 64'h3FFF_FFF3_FFFF_FF3F;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[63:62] == 2'b00 && cfg_rdata[35:34] == 2'b00 && cfg_rdata[7:6] == 2'b00);

  // R2
  reset_word_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_rdata == (RESET_WORD & KEEP));

  // R3
  write_apply_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & KEEP));

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));

  // R4
  rom_prop_chk: assert property (@(posedge clk) disable iff (rst)
    zone_out == 2'd2 |-> prop_out == {2'b00, cfg_rdata[61:56]});

  // R5
  dev_prop_chk: assert property (@(posedge clk) disable iff (rst)
    zone_out == 2'd1 |-> prop_out == {2'b00, cfg_rdata[33:28]});

  // R6
  sys_prop_chk: assert property (@(posedge clk) disable iff (rst)
    zone_out == 2'd0 |-> prop_out == {2'b00, cfg_rdata[5:0]});

  // R7
  leg_window_chk: assert property (@(posedge clk) disable iff (rst)
    zone_out == 2'd3 |-> (phys_addr >= WIN_LO && phys_addr <= WIN_HI));

  // R8
  flag_map_chk: assert property (@(posedge clk) disable iff (rst)
    {attr_ws, attr_wc, attr_wt, attr_wp, attr_wa, attr_cd} == prop_out[5:0]);

  // R9
  prop_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    prop_out[7:6] == 2'b00);
endmodule

bind mem_region_decode mrd_chk #(.RESET_WORD(RESET_WORD), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .phys_addr(phys_addr), .prop_out(prop_out), .zone_out(zone_out),
  .attr_cd(attr_cd), .attr_wa(attr_wa), .attr_wp(attr_wp),
  .attr_wt(attr_wt), .attr_wc(attr_wc), .attr_ws(attr_ws)
);

// File: tb/mem_region_decode_tb.sv
`timescale 1ns/1ps
module mem_region_decode_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic [31:0] phys_addr = '0;
  logic [7:0]  legacy_prop = '0;
  logic [7:0]  prop_out;
  logic [1:0]  zone_out;
  logic attr_cd, attr_wa, attr_wp, attr_wt, attr_wc, attr_ws;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] ref_cfg;
  logic [31:0] rng = 32'h1234_5678;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_region_decode u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .phys_addr(phys_addr), .legacy_prop(legacy_prop), .prop_out(prop_out), .zone_out(zone_out),
    .attr_cd(attr_cd), .attr_wa(attr_wa), .attr_wp(attr_wp),
    .attr_wt(attr_wt), .attr_wc(attr_wc), .attr_ws(attr_ws)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // drive one cycle, compare all outputs against the behavioural model
  task automatic step(input logic [31:0] a, input logic [7:0] lp,
                      input logic we, input logic [63:0] wd);
    int page, base, top, zone;
    logic [7:0] exp_p;
    string tag;
    @(negedge clk);
    phys_addr = a; legacy_prop = lp; cfg_we = we; cfg_wdata = wd;
    #1;
    page = int'(a >> 12);
    base = int'(ref_cfg[55:36]);
    top  = int'(ref_cfg[27:8]);
    if (page >= base) begin
      zone = 2; exp_p = ref_cfg[63:56]; tag = "R4";
    end else if (page >= top) begin
      zone = 1; exp_p = ref_cfg[35:28]; tag = "R5";
    end else if (a >= 32'h000A_0000 && a <= 32'h000F_FFFF) begin
      zone = 3; exp_p = lp; tag = "R7";
    end else begin
      zone = 0; exp_p = ref_cfg[7:0]; tag = "R6";
    end
    exp_p[7:6] = 2'b00;
    check({tag, " zone"}, 64'(zone_out), 64'(zone));
    check({tag, " prop"}, 64'(prop_out), 64'(exp_p));
    check("R8 flags", 64'({attr_ws, attr_wc, attr_wt, attr_wp, attr_wa, attr_cd}), 64'(exp_p[5:0]));
    check("R9 prop reserved", 64'(prop_out[7:6]), 64'd0);
    check("R1 R3 readback", cfg_rdata, ref_cfg);
    if (we) ref_cfg = wd & 64'h3FFF_FFF3_FFFF_FF3F;
  endtask

  function automatic logic [63:0] mk(input logic [7:0] rp, input logic [19:0] bp,
                                     input logic [7:0] dp, input logic [19:0] tp,
                                     input logic [7:0] sp);
    return {rp, bp, dp, tp, sp};
  endfunction

  initial begin
    ref_cfg = 64'h01FF_FFF0_1000_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R2 reset word
    check("R2 reset value", cfg_rdata, 64'h01FF_FFF0_1000_0001);
    rst = 1'b0;
    // R2 every zone cache-disabled after reset
    step(32'h0000_0000, 8'h3F, 0, '0);
    step(32'h000A_0000, 8'h3F, 0, '0);
    step(32'hFFFF_EFFF, 8'h00, 0, '0);
    step(32'hFFFF_F000, 8'h00, 0, '0);
    // R1 R3 write with reserved bits set
    step(32'h0000_0000, 8'h00, 1, mk(8'hFC, 20'hFFF00, 8'hC5, 20'h08000, 8'hCA));
    step(32'h0000_0000, 8'hD0, 0, '0);
    step(32'h0009_FFFF, 8'hD0, 0, '0);
    step(32'h000A_0000, 8'hD0, 0, '0);
    step(32'h000F_FFFF, 8'h21, 0, '0);
    step(32'h0010_0000, 8'h21, 0, '0);
    step(32'h07FF_FFFF, 8'h21, 0, '0);
    step(32'h0800_0000, 8'h21, 0, '0);
    step(32'hFFEF_FFFF, 8'h21, 0, '0);
    step(32'hFFF0_0000, 8'h21, 0, '0);
    step(32'hFFFF_FFFF, 8'h21, 0, '0);
    // R4 top above base: ROM wins, legacy still applies in system zone
    step(32'h0000_0000, 8'h00, 1, mk(8'h12, 20'h10000, 8'h24, 20'hFFFF0, 8'h08));
    step(32'h2000_0000, 8'h3F, 0, '0);
    step(32'h0FFF_FFFF, 8'h3F, 0, '0);
    step(32'h000A_5000, 8'hFF, 0, '0);
    // R7 legacy window inside device zone has no effect
    step(32'h0000_0000, 8'h00, 1, mk(8'h01, 20'hFFFFF, 8'h10, 20'h00050, 8'h02));
    step(32'h000B_0000, 8'h3E, 0, '0);
    step(32'h0004_FFFF, 8'h3E, 0, '0);
    // mixed traffic with occasional writes
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [63:0] w;
      rng = next_rng(rng); a = rng;
      if (i % 4 == 0) a = 32'h0009_0000 + (a & 32'h0007_FFFF);
      rng = next_rng(rng); w[31:0] = rng;
      rng = next_rng(rng); w[63:32] = rng;
      if (i % 3 == 0) w[27:8] = w[27:8] >> 11;
      step(a, rng[7:0], (i % 25 == 7), w);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule